// File: doc/BRIEF.md
# Local Interrupt Controller Register Front End

This block is the 32-bit register face of a per-processor interrupt controller. It decodes accesses that fall in a 4 KB window, holds the registers that software owns directly, and passes values and single-cycle strobes to the timer and the interrupt prioritizer. Those two engines live outside the block. Status that belongs to them, such as the in-service, trigger-mode and request banks, the processor priority and the running count, is fetched through plain ports.

Accesses use a valid/ready request channel and a valid/ready response channel. A request is taken on a rising edge when `req_valid` and `req_ready` are both high. Every taken request, read or write, produces exactly one response on the following cycle; write responses carry zero data. `req_ready` stays high unless a response is waiting with `rsp_ready` low. In that case the response and its data are held, and no new request is taken until the response is consumed. A response can be consumed and a new request taken on the same edge.

The base-address register is not in the window. It has its own write port, because the processor reaches it through a separate configuration path. Once the controller has been switched off there, it cannot be switched back on.

Top module: `irqc_regif`

## Requirements
- R1: A request taken on edge N gives `rsp_valid` high after edge N. While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_rdata` and `req_ready`=0 hold, and the pending request is not taken.
- R2: The register index is `req_addr[11:4]`. `req_addr[3:0]` has no effect.
- R3: Index 0x03 reads 0x00050011: the version 0x11 in bits 7:0 and the number of vector-table entries less one (5) in bits 23:16.
- R4: Index 0x0F (spurious vector) resets to 0x0FF. A write keeps `req_wdata[8:0]`, and reads return the 9-bit value. `spur_q` shows it.
- R5: Indices 0x32..0x37 are six vector-table entries, in the order timer, thermal, performance, local input 0, local input 1, error. Each resets to 0x00010000 (mask bit 16) and reads back what was written. A write to 0x32 pulses `lvt_timer_wr` for one cycle, and `lvt_timer` shows entry 0x32.
- R6: Indices 0x10..0x17, 0x18..0x1F and 0x20..0x27 read the in-service, trigger-mode and request banks. `stat_bank` is 0, 1 or 2 respectively (3 otherwise), `stat_word` is index[2:0], and the read returns `stat_data`.
- R7: Indices 0x30 and 0x31 are the low and high command words, selected by index[0], readable and visible on `icr_q`. A write to 0x30 pulses `icr_send` for one cycle.
- R8: Index 0x38 (initial count, reset 0) is read/write, and a write to it pulses `init_load` for one cycle. Index 0x39 reads `cur_count`. Index 0x3E keeps `wdata & 0xB` on `divide_cfg`.
- R9: Index 0x28 reads the error word, where bit 7 is the illegal-access flag (reset 0). Writing 0x28 clears it. Any access to an undefined index reads 0 and sets bit 7. A write to a read-only index (0x03, 0x0A, 0x10..0x27, 0x39) changes nothing and also sets bit 7.
- R10: Index 0x0A reads `ppr_in` zero-extended. A write to 0x0B pulses `eoi_pulse` for one cycle. A read of 0x0B returns 0 and raises no error.
- R11: `base_q` resets to 0xFEE00900, with the boot-processor flag in bit 8 and the enable flag in bit 11. A `base_wr` loads bits 31:12 from `base_wdata`, keeps bit 8, and clears bits 10:9 and 7:0.
- R12: A `base_wr` with bit 11 clear clears the enable flag for good, and also clears spurious bit 8; this overrides a spurious write taken on the same edge. A later write with bit 11 set leaves enable at 0. Software may set spurious bit 8 again afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address in the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| base_wr | input | 1 | Base-register write strobe |
| base_wdata | input | 32 | Base-register write data |
| base_q | output | 32 | Base register |
| spur_q | output | 9 | Spurious-vector register |
| stat_bank | output | 2 | Status bank being read |
| stat_word | output | 3 | Word within the bank |
| stat_data | input | 32 | Status word returned by the prioritizer |
| ppr_in | input | 8 | Processor priority |
| cur_count | input | 32 | Timer running count |
| eoi_pulse | output | 1 | End-of-interrupt strobe |
| icr_q | output | 64 | Command register, high word in bits 63:32 |
| icr_send | output | 1 | Command issue strobe |
| init_count | output | 32 | Timer initial count |
| init_load | output | 1 | Initial-count load strobe |
| divide_cfg | output | 4 | Timer divide configuration |
| lvt_timer | output | 32 | Timer vector-table entry |
| lvt_timer_wr | output | 1 | Timer entry write strobe |

## Verification
Every result of an access is due one edge after the request is taken: read data, `rsp_valid`, register contents, the error flag and the strobes. The base-register effects are due one edge after `base_wr`. The bench drives on falling edges and samples at the next falling edge, so each check falls inside the cycle where its result first appears. Every index is swept by reads, then by writes, then by reads again with a different low address nibble, and each read is compared with a model updated arithmetically. A stalled response is held for several cycles and checked at each falling edge before it is released.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int DATA_W     = 32;
  localparam int IDX_W      = 8;
  localparam int BANK_WORDS = 8;
  localparam int SPUR_W     = 9;
  localparam int ESR_BIT    = 7;
  localparam int BSP_BIT    = 8;
  localparam int EN_BIT     = 11;

  localparam logic [IDX_W-1:0] IDX_VER  = 8'h03;
  localparam logic [IDX_W-1:0] IDX_PPR  = 8'h0A;
  localparam logic [IDX_W-1:0] IDX_EOI  = 8'h0B;
  localparam logic [IDX_W-1:0] IDX_SPUR = 8'h0F;
  localparam logic [IDX_W-1:0] IDX_ISR  = 8'h10;
  localparam logic [IDX_W-1:0] IDX_TMR  = 8'h18;
  localparam logic [IDX_W-1:0] IDX_IRR  = 8'h20;
  localparam logic [IDX_W-1:0] IDX_ESR  = 8'h28;
  localparam logic [IDX_W-1:0] IDX_ICR  = 8'h30;
  localparam logic [IDX_W-1:0] IDX_LVT  = 8'h32;
  localparam logic [IDX_W-1:0] IDX_INIT = 8'h38;
  localparam logic [IDX_W-1:0] IDX_CUR  = 8'h39;
  localparam logic [IDX_W-1:0] IDX_DIV  = 8'h3E;

  typedef enum logic [3:0] {
    K_NONE, K_VER, K_PPR, K_EOI, K_SPUR, K_ISR, K_TMR, K_IRR,
    K_ESR, K_ICR, K_LVT, K_INIT, K_CUR, K_DIV
  } reg_kind_e;
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
  import irqc_pkg::*;
#(
  parameter int LVT_N = 6,
  parameter int SEL_W = 3
) (
  input  logic [IDX_W-1:0] idx,
  output reg_kind_e        kind,
  output logic             read_only,
  output logic [SEL_W-1:0] lvt_sel,
  output logic [1:0]       bank
);
  localparam logic [IDX_W-1:0] BANK_SPAN = IDX_W'(BANK_WORDS);
  localparam logic [IDX_W-1:0] LVT_SPAN  = IDX_W'(LVT_N);

  always_comb begin
    kind = K_NONE;
    if (idx == IDX_VER)                                    kind = K_VER;
    else if (idx == IDX_PPR)                               kind = K_PPR;
    else if (idx == IDX_EOI)                               kind = K_EOI;
    else if (idx == IDX_SPUR)                              kind = K_SPUR;
    else if (idx >= IDX_ISR && idx < IDX_ISR + BANK_SPAN)  kind = K_ISR;
    else if (idx >= IDX_TMR && idx < IDX_TMR + BANK_SPAN)  kind = K_TMR;
    else if (idx >= IDX_IRR && idx < IDX_IRR + BANK_SPAN)  kind = K_IRR;
    else if (idx == IDX_ESR)                               kind = K_ESR;
    else if (idx[IDX_W-1:1] == IDX_ICR[IDX_W-1:1])         kind = K_ICR;
    else if (idx >= IDX_LVT && idx < IDX_LVT + LVT_SPAN)   kind = K_LVT;
    else if (idx == IDX_INIT)                              kind = K_INIT;
    else if (idx == IDX_CUR)                               kind = K_CUR;
    else if (idx == IDX_DIV)                               kind = K_DIV;
  end

  always_comb begin
    read_only = (kind == K_VER) || (kind == K_PPR) || (kind == K_ISR) ||
                (kind == K_TMR) || (kind == K_IRR) || (kind == K_CUR);
  end

  always_comb begin
    case (kind)
      K_ISR:   bank = 2'd0;
      K_TMR:   bank = 2'd1;
      K_IRR:   bank = 2'd2;
      default: bank = 2'd3;
    endcase
  end

  logic [IDX_W-1:0] lvt_off;
  assign lvt_off = idx - IDX_LVT;
  assign lvt_sel = lvt_off[SEL_W-1:0];

  logic unused_off;
  assign unused_off = ^lvt_off[IDX_W-1:SEL_W];
endmodule

// File: rtl/irqc_lvt_bank.sv
module irqc_lvt_bank
  import irqc_pkg::*;
#(
  parameter int                LVT_N     = 6,
  parameter int                SEL_W     = 3,
  parameter logic [DATA_W-1:0] LVT_RESET = 32'h0001_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] entry0
);
  logic [DATA_W-1:0] ent [LVT_N];

  for (genvar g = 0; g < LVT_N; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)                                ent[g] <= LVT_RESET;
      else if (wr_en && sel == SEL_W'(g))        ent[g] <= wdata;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < LVT_N; i++)
      if (sel == SEL_W'(i)) rd_data = ent[i];
  end

  assign entry0 = ent[0];
endmodule

// File: rtl/irqc_base_reg.sv
module irqc_base_reg
  import irqc_pkg::*;
#(
  parameter logic [DATA_W-1:0] ADDR_RESET = 32'hFEE0_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_wr,
  input  logic [DATA_W-1:0] base_wdata,
  output logic [DATA_W-1:0] base_q,
  output logic              sw_off
);
  localparam logic [DATA_W-1:0] FLAGS_RESET = (DATA_W'(1) << BSP_BIT) | (DATA_W'(1) << EN_BIT);

  logic [DATA_W-1:0] next_q;

  always_comb begin
    next_q            = '0;
    next_q[DATA_W-1:12] = base_wdata[DATA_W-1:12];
    next_q[EN_BIT]    = base_q[EN_BIT] & base_wdata[EN_BIT];
    next_q[BSP_BIT]   = base_q[BSP_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       base_q <= (ADDR_RESET & 32'hFFFF_F000) | FLAGS_RESET;
    else if (base_wr) base_q <= next_q;
  end

  assign sw_off = base_wr && !base_wdata[EN_BIT];

  logic unused_low;
  assign unused_low = ^base_wdata[10:0];

  // R12: once off, the enable flag never returns
  a_r12_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !base_q[EN_BIT] |=> !base_q[EN_BIT]);

  // R11: the boot-processor flag is never changed by a write
  a_r11_bsp_kept: assert property (@(posedge clk) disable iff (!rst_n)
    base_wr |=> $stable(base_q[BSP_BIT]));
endmodule

// File: rtl/irqc_regif.sv
module irqc_regif
  import irqc_pkg::*;
#(
  parameter int                ADDR_W     = 12,
  parameter int                LVT_N      = 6,
  parameter logic [31:0]       BASE_RESET = 32'hFEE0_0000,
  parameter logic [SPUR_W-1:0] SPUR_RESET = 9'h0FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [11:0]       req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  input  logic              base_wr,
  input  logic [31:0]       base_wdata,
  output logic [31:0]       base_q,
  output logic [8:0]        spur_q,
  output logic [1:0]        stat_bank,
  output logic [2:0]        stat_word,
  input  logic [31:0]       stat_data,
  input  logic [7:0]        ppr_in,
  input  logic [31:0]       cur_count,
  output logic              eoi_pulse,
  output logic [63:0]       icr_q,
  output logic              icr_send,
  output logic [31:0]       init_count,
  output logic              init_load,
  output logic [3:0]        divide_cfg,
  output logic [31:0]       lvt_timer,
  output logic              lvt_timer_wr
);
  localparam int SEL_W = (LVT_N > 1) ? $clog2(LVT_N) : 1;
  localparam logic [DATA_W-1:0] VERSION_WORD = {8'h00, 8'(LVT_N - 1), 8'h00, 8'h11};
  localparam logic [3:0] DIV_MASK = 4'hB;

  // request index and decode
  logic [IDX_W-1:0] idx;
  assign idx = req_addr[ADDR_W-1:4];
  logic unused_nib;
  assign unused_nib = ^req_addr[3:0];

  reg_kind_e        kind;
  logic             ro;
  logic [SEL_W-1:0] lvt_sel;

  irqc_decode #(.LVT_N(LVT_N), .SEL_W(SEL_W)) u_dec (
    .idx(idx), .kind(kind), .read_only(ro), .lvt_sel(lvt_sel), .bank(stat_bank)
  );
  assign stat_word = idx[2:0];

  // handshake
  logic acc, wr_acc, bad;
  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign wr_acc    = acc && req_write;
  assign bad       = (kind == K_NONE) || (req_write && ro);

  // base register
  logic sw_off;
  irqc_base_reg #(.ADDR_RESET(BASE_RESET)) u_base (
    .clk(clk), .rst_n(rst_n), .base_wr(base_wr), .base_wdata(base_wdata),
    .base_q(base_q), .sw_off(sw_off)
  );

  // vector table
  logic [DATA_W-1:0] lvt_rd;
  irqc_lvt_bank #(.LVT_N(LVT_N), .SEL_W(SEL_W)) u_lvt (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_acc && kind == K_LVT), .sel(lvt_sel),
    .wdata(req_wdata), .rd_data(lvt_rd), .entry0(lvt_timer)
  );

  // software-owned registers
  logic esr_err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      spur_q <= SPUR_RESET;
    end else begin
      if (wr_acc && kind == K_SPUR) spur_q <= req_wdata[SPUR_W-1:0];
      if (sw_off)                   spur_q[SPUR_W-1] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      icr_q      <= '0;
      init_count <= '0;
      divide_cfg <= '0;
    end else if (wr_acc) begin
      if (kind == K_ICR && !idx[0]) icr_q[31:0]  <= req_wdata;
      if (kind == K_ICR &&  idx[0]) icr_q[63:32] <= req_wdata;
      if (kind == K_INIT)           init_count   <= req_wdata;
      if (kind == K_DIV)            divide_cfg   <= req_wdata[3:0] & DIV_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                         esr_err <= 1'b0;
    else if (wr_acc && kind == K_ESR)   esr_err <= 1'b0;
    else if (acc && bad)                esr_err <= 1'b1;
  end

  // one-cycle strobes to the timer and prioritizer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eoi_pulse    <= 1'b0;
      icr_send     <= 1'b0;
      init_load    <= 1'b0;
      lvt_timer_wr <= 1'b0;
    end else begin
      eoi_pulse    <= wr_acc && kind == K_EOI;
      icr_send     <= wr_acc && kind == K_ICR && !idx[0];
      init_load    <= wr_acc && kind == K_INIT;
      lvt_timer_wr <= wr_acc && kind == K_LVT && lvt_sel == '0;
    end
  end

  // read mux
  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    case (kind)
      K_VER:               rd_mux = VERSION_WORD;
      K_PPR:               rd_mux = {24'h0, ppr_in};
      K_SPUR:              rd_mux = {{(DATA_W-SPUR_W){1'b0}}, spur_q};
      K_ISR, K_TMR, K_IRR: rd_mux = stat_data;
      K_ESR:               rd_mux = {24'h0, esr_err, 7'h0};
      K_ICR:               rd_mux = idx[0] ? icr_q[63:32] : icr_q[31:0];
      K_LVT:               rd_mux = lvt_rd;
      K_INIT:              rd_mux = init_count;
      K_CUR:               rd_mux = cur_count;
      K_DIV:               rd_mux = {28'h0, divide_cfg};
      default:             rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (acc) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= req_write ? '0 : rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R1: a stalled response holds its data
  a_r1_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

  // R8: a load strobe follows a taken write
  a_r8_load_src: assert property (@(posedge clk) disable iff (!rst_n)
    init_load |-> $past(req_valid && req_ready && req_write));

  // R9: the error flag stays set until its register is written
  a_r9_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
    esr_err && !(wr_acc && kind == K_ESR) |=> esr_err);

  // R4: the enable bit of the spurious register rises only from a write to it
  a_r4_spur_set: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spur_q[SPUR_W-1]) |-> $past(wr_acc && kind == K_SPUR));
endmodule

// File: tb/irqc_regif_test.sv
module irqc_regif_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req_valid = 0, req_write = 0, rsp_ready = 1, base_wr = 0;
  logic [11:0] req_addr = 0;
  logic [31:0] req_wdata = 0, base_wdata = 0;
  logic        req_ready, rsp_valid, eoi_pulse, icr_send, init_load, lvt_timer_wr;
  logic [31:0] rsp_rdata, base_q, init_count, lvt_timer, stat_data;
  logic [8:0]  spur_q;
  logic [1:0]  stat_bank;
  logic [2:0]  stat_word;
  logic [63:0] icr_q;
  logic [3:0]  divide_cfg;
  logic [7:0]  ppr_in = 8'h3C;
  logic [31:0] cur_count = 32'h0000_7777;

  function automatic logic [31:0] stat_fn(logic [1:0] b, logic [2:0] w);
    return 32'h0100_0000 * (32'(b) + 1) + 32'(w) * 32'h0000_0211 + 32'h0000_00A0;
  endfunction
  assign stat_data = stat_fn(stat_bank, stat_word);

  irqc_regif uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .base_wr(base_wr), .base_wdata(base_wdata), .base_q(base_q), .spur_q(spur_q),
    .stat_bank(stat_bank), .stat_word(stat_word), .stat_data(stat_data),
    .ppr_in(ppr_in), .cur_count(cur_count), .eoi_pulse(eoi_pulse), .icr_q(icr_q),
    .icr_send(icr_send), .init_count(init_count), .init_load(init_load),
    .divide_cfg(divide_cfg), .lvt_timer(lvt_timer), .lvt_timer_wr(lvt_timer_wr)
  );

  int tests = 0, fails = 0;
  bit done = 0;

  // model state
  logic [8:0]  m_sv = 9'h0FF;
  logic [31:0] m_lvt [6];
  logic [31:0] m_icr [2];
  logic [31:0] m_init = 0;
  logic [3:0]  m_div = 0;
  logic        m_esr = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit is_def(logic [7:0] i);
    return i == 8'h03 || i == 8'h0A || i == 8'h0B || i == 8'h0F ||
           (i >= 8'h10 && i <= 8'h28) || (i >= 8'h30 && i <= 8'h39) || i == 8'h3E;
  endfunction

  function automatic bit is_ro(logic [7:0] i);
    return i == 8'h03 || i == 8'h0A || (i >= 8'h10 && i <= 8'h27) || i == 8'h39;
  endfunction

  function automatic logic [31:0] exp_rd(logic [7:0] i);
    if (i == 8'h03) return 32'h0005_0011;
    if (i == 8'h0A) return {24'h0, ppr_in};
    if (i == 8'h0F) return {23'h0, m_sv};
    if (i >= 8'h10 && i <= 8'h17) return stat_fn(2'd0, i[2:0]);
    if (i >= 8'h18 && i <= 8'h1F) return stat_fn(2'd1, i[2:0]);
    if (i >= 8'h20 && i <= 8'h27) return stat_fn(2'd2, i[2:0]);
    if (i == 8'h28) return {24'h0, m_esr, 7'h0};
    if (i == 8'h30 || i == 8'h31) return m_icr[i[0]];
    if (i >= 8'h32 && i <= 8'h37) return m_lvt[i - 8'h32];
    if (i == 8'h38) return m_init;
    if (i == 8'h39) return cur_count;
    if (i == 8'h3E) return {28'h0, m_div};
    return 32'h0;
  endfunction

  function automatic logic [31:0] pat(logic [7:0] i);
    return {i, ~i, i ^ 8'h5A, 8'hC3};
  endfunction

  task automatic access(input logic w, input logic [7:0] i, input logic [3:0] nib,
                        input logic [31:0] d, output logic [31:0] rd);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = {i, nib}; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    rd = rsp_rdata;
  endtask

  task automatic read_sweep(input logic [3:0] nib);
    for (int k = 0; k < 256; k++) begin
      logic [7:0]  i = 8'(k);
      logic [31:0] e = exp_rd(i);
      logic [31:0] rd;
      access(1'b0, i, nib, 32'h0, rd);
      if (!is_def(i))                         chk("R9 undefined read", rd, e);
      else if (i >= 8'h10 && i <= 8'h27)      chk("R6 bank read", rd, e);
      else if (i >= 8'h32 && i <= 8'h37)      chk("R5 vector table read", rd, e);
      else if (i == 8'h03)                    chk("R3 version", rd, e);
      else                                    chk("R2 R4 R7 R8 R10 register read", rd, e);
      if (!is_def(i)) m_esr = 1;
    end
  endtask

  initial begin
    logic [31:0] rd;
    for (int k = 0; k < 6; k++) m_lvt[k] = 32'h0001_0000;
    m_icr[0] = 0; m_icr[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // reset state
    chk("R11 base reset", base_q, 32'hFEE0_0900);
    chk("R1 reset handshake", {rsp_valid, req_ready}, 2'b01);
    chk("R4 spurious reset", spur_q, 9'h0FF);
    chk("R5 timer entry reset", lvt_timer, 32'h0001_0000);
    chk("R8 initial count reset", init_count, 0);

    // reads of every index from reset
    read_sweep(4'h0);

    // writes to every index
    for (int k = 0; k < 256; k++) begin
      logic [7:0]  i = 8'(k);
      logic [31:0] p = pat(i);
      access(1'b1, i, 4'h4, p, rd);
      chk("R5 R7 R8 R10 strobes", {eoi_pulse, icr_send, init_load, lvt_timer_wr},
          {i == 8'h0B, i == 8'h30, i == 8'h38, i == 8'h32});
      if (i == 8'h38) chk("R8 initial count port", init_count, p);
      if (i == 8'h32) chk("R5 timer entry port", lvt_timer, p);
      if (i == 8'h3E) chk("R8 divide masked", divide_cfg, p[3:0] & 4'hB);
      if (i == 8'h31) chk("R7 command port", icr_q, {p, pat(8'h30)});
      if (!is_def(i) || is_ro(i)) m_esr = 1;
      if (i == 8'h28) m_esr = 0;
      if (i == 8'h0F) m_sv = p[8:0];
      if (i == 8'h30 || i == 8'h31) m_icr[i[0]] = p;
      if (i >= 8'h32 && i <= 8'h37) m_lvt[i - 8'h32] = p;
      if (i == 8'h38) m_init = p;
      if (i == 8'h3E) m_div = p[3:0] & 4'hB;
    end
    chk("R9 error flag after writes", {31'h0, m_esr}, 1);

    // read back with another low nibble
    read_sweep(4'hB);

    // clear error then a read-only write sets it
    access(1'b1, 8'h28, 4'h0, 32'hFFFF_FFFF, rd);
    access(1'b0, 8'h28, 4'h0, 0, rd);
    chk("R9 error cleared", rd, 32'h0);
    access(1'b1, 8'h39, 4'h0, 32'h1234, rd);
    access(1'b0, 8'h28, 4'h0, 0, rd);
    chk("R9 read-only write sets error", rd, 32'h80);
    access(1'b0, 8'h39, 4'h0, 0, rd);
    chk("R9 read-only write ignored", rd, cur_count);

    // back-pressure
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_write = 0; req_addr = 12'h030;
    @(negedge clk);
    req_write = 1; req_addr = 12'h0F0; req_wdata = 32'h0000_01AB;
    chk("R1 stalled response", {rsp_valid, req_ready, rsp_rdata}, {2'b10, 32'h0005_0011});
    repeat (2) @(negedge clk);
    chk("R1 stalled response held", {rsp_valid, req_ready, rsp_rdata}, {2'b10, 32'h0005_0011});
    chk("R1 pending write not taken", spur_q, m_sv);
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    chk("R1 write taken on release", {rsp_valid, spur_q}, {1'b1, 9'h1AB});
    access(1'b0, 8'h0F, 4'h0, 0, rd);
    chk("R4 spurious readback", rd, 32'h1AB);

    // base register rules
    @(negedge clk); base_wr = 1; base_wdata = 32'h1234_5E00;
    @(negedge clk); base_wr = 0;
    chk("R11 base write keeps flags", base_q, 32'h1234_5900);
    @(negedge clk);
    base_wr = 1; base_wdata = 32'hABCD_E000;
    req_valid = 1; req_write = 1; req_addr = 12'h0F0; req_wdata = 32'h1FF;
    @(negedge clk);
    base_wr = 0; req_valid = 0;
    chk("R12 disable base", base_q, 32'hABCD_E100);
    chk("R12 disable clears spurious bit 8", spur_q, 9'h0FF);
    @(negedge clk); base_wr = 1; base_wdata = 32'h0000_0800;
    @(negedge clk); base_wr = 0;
    chk("R12 enable stays off", base_q, 32'h0000_0100);
    access(1'b1, 8'h0F, 4'h0, 32'h1FF, rd);
    access(1'b0, 8'h0F, 4'h0, 0, rd);
    chk("R12 spurious bit 8 settable after disable", rd, 32'h1FF);
    @(negedge clk); base_wr = 1; base_wdata = 32'h0000_0000;
    @(negedge clk); base_wr = 0;
    chk("R12 repeated disable clears bit 8", spur_q, 9'h0FF);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule